// File: doc/BRIEF.md
# Idle-Word Trained Lane Aligner

The block takes the data lanes of an image sensor (two by default) after they have been sampled into single-ended logic. Each lane delivers two bits per fast clock, one from each clock edge. For each lane the block assembles a parallel word every half word-width of cycles, which is five cycles for the default 10-bit word. While the sensor is idle it repeats a fixed idle word. A per-lane trainer compares the assembled words with that word. When a word does not match, the trainer moves the word boundary by one bit. It then ignores a fixed number of words while the new boundary settles, and compares again. After enough consecutive matches the lane reports lock.

Each lane trains and locks on its own. The training-enable input controls both the search and the loss-of-lock detection. While it is low, a lane keeps whatever lock state it has, so image data cannot pull it out of alignment. A lane that uses up its slip budget without a single match raises a fail flag and keeps searching.

The output side is valid-only. Sensor data cannot be stalled, so there is no ready input and no back-pressure. Each word is presented for exactly one cycle with its valid strobe, and a consumer must accept it in that cycle.

Top module: `idle_lane_aligner`

## Requirements
- R1: On each lane the bit on `ser_first` is earlier in the stream than the bit on `ser_second` of the same cycle. The earliest bit of a word appears in its most significant bit.
- R2: Once a lane is locked, the words it delivers equal the words the sensor sent, in the same order and with none skipped.
- R3: A lane asserts lock only after 8 consecutive compared words equal the idle word (default 10'h2E6). While a locked lane receives idle, every delivered word equals the idle word.
- R4: From any initial bit skew of 0 to 9, a lane locks without raising its fail flag.
- R5: Each slip moves the sampled boundary one bit earlier in the stream. After a slip, the next 4 words are not compared. For a lane whose idle words start k bits after reset, lock therefore rises right after valid strobe number 5·((10−k) mod 10)+8.
- R6: While `train_en` is low, a locked lane stays locked whatever it receives, and an unlocked lane does not slip and does not lock.
- R7: While `train_en` is high, a locked lane drops lock on the 4th consecutive non-idle word. Matching words keep the lock.
- R8: After 10 slips with no matching word in between, the lane sets its fail flag, clears its slip count and keeps searching. The flag clears when the lane next locks.
- R9: Lanes are independent: each lane's lock, slips and fail flag depend only on its own input bits.
- R10: A synchronous active-high reset clears lock, fail and valid on every lane.
- R11: `rx_valid` of a lane is a single-cycle pulse, repeating exactly every 5 cycles after reset. No back-pressure exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one bit pair per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| train_en | input | 1 | Enables search, slipping and loss-of-lock detection |
| ser_first | input | LANES | Per lane, the earlier bit of the cycle |
| ser_second | input | LANES | Per lane, the later bit of the cycle |
| rx_word | output | LANES*WORD_W | Aligned words; lane n in bits n*WORD_W upward |
| rx_valid | output | LANES | One-cycle strobe per delivered word |
| lane_locked | output | LANES | Lane aligned to the idle word |
| lane_fail | output | LANES | Slip budget spent without a match |

## Verification
A word's valid strobe appears in the cycle after the clock edge that samples its fifth bit pair. A slip decided on one strobe takes effect for the word delivered five cycles later, so lock rises one cycle after strobe number 5·s+8, where s is the number of slips the skew requires. The bench drives and samples only on falling edges. It counts valid strobes per lane from reset release and compares the strobe count at the first locked sample with that formula. It checks the spacing of strobes in cycles. Where only ordering matters, such as payload pass-through and the drop after a switch to non-idle data, it searches for a marker word or waits within a bound.

// File: rtl/lanealign_pkg.sv
`timescale 1ns/1ps
package lanealign_pkg;

  typedef enum logic [1:0] {
    TR_HUNT   = 2'd0,
    TR_SETTLE = 2'd1,
    TR_LOCKED = 2'd2
  } tr_state_e;

  // True when the low n bits of w equal some non-zero rotation of themselves.
  function automatic bit rot_symmetric(input logic [63:0] w, input int n);
    bit any;
    any = 1'b0;
    for (int r = 1; r < n; r++) begin
      bit same;
      same = 1'b1;
      for (int i = 0; i < n; i++) begin
        if (w[i] != w[(i + r) % n]) same = 1'b0;
      end
      if (same) any = 1'b1;
    end
    return any;
  endfunction

endpackage

// File: rtl/lane_gearbox.sv
`timescale 1ns/1ps
module lane_gearbox #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_early,
  input  logic              bit_late,
  input  logic              slip,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  localparam int CYC = WORD_W / 2;
  localparam int HD  = 2 * WORD_W - 1;
  localparam int HQ  = HD - 2;
  localparam int CW  = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int OW  = $clog2(WORD_W);
  localparam int GW  = $clog2(CYC + 1) + 1;

  logic [HQ-1:0] hist_q;
  logic [HD-1:0] hist_d;
  logic [CW-1:0] ph_q;
  logic [OW-1:0] off_q;

  // newest bits at the low end, earlier bit above the later one
  assign hist_d = {hist_q, bit_early, bit_late};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      ph_q     <= '0;
      off_q    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      hist_q   <= hist_d[HQ-1:0];
      word_vld <= 1'b0;
      if (ph_q == CW'(CYC - 1)) begin
        ph_q     <= '0;
        word     <= hist_d[off_q +: WORD_W];
        word_vld <= 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
      if (slip) begin
        off_q <= (off_q == OW'(WORD_W - 1)) ? '0 : off_q + 1'b1;
      end
    end
  end

  // strobe spacing checker
  logic [GW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_vld) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R11
  strobe_period_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && seen_q) |-> (gap_q == GW'(CYC)));

  initial begin
    // R1
    even_width_chk: assert (WORD_W % 2 == 0 && WORD_W >= 4)
      else $error("word width must be even and at least 4");
  end
endmodule

// File: rtl/lane_trainer.sv
`timescale 1ns/1ps
module lane_trainer
  import lanealign_pkg::*;
#(
  parameter int              WORD_W       = 10,
  parameter logic [WORD_W-1:0] IDLE_WORD  = 10'h2E6,
  parameter int              SETTLE_WORDS = 4,
  parameter int              LOCK_WORDS   = 8,
  parameter int              UNLOCK_WORDS = 4,
  parameter int              MAX_SLIPS    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_en,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic              slip,
  output logic              locked,
  output logic              fail
);
  localparam int SW = $clog2(SETTLE_WORDS + 1);
  localparam int LW = $clog2(LOCK_WORDS + 1);
  localparam int UW = $clog2(UNLOCK_WORDS + 1);
  localparam int MW = $clog2(MAX_SLIPS + 1);
  localparam int GW = $clog2(SETTLE_WORDS + 2);

  tr_state_e   state_q;
  logic [SW-1:0] settle_q;
  logic [LW-1:0] run_q;
  logic [UW-1:0] miss_q;
  logic [MW-1:0] slips_q;
  logic          hit;

  assign hit = (word == IDLE_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TR_HUNT;
      settle_q <= '0;
      run_q    <= '0;
      miss_q   <= '0;
      slips_q  <= '0;
      slip     <= 1'b0;
      locked   <= 1'b0;
      fail     <= 1'b0;
    end else begin
      slip <= 1'b0;
      if (word_vld) begin
        case (state_q)
          TR_HUNT: begin
            if (train_en) begin
              if (hit) begin
                slips_q <= '0;
                if (run_q == LW'(LOCK_WORDS - 1)) begin
                  run_q   <= '0;
                  locked  <= 1'b1;
                  fail    <= 1'b0;
                  miss_q  <= '0;
                  state_q <= TR_LOCKED;
                end else begin
                  run_q <= run_q + 1'b1;
                end
              end else begin
                run_q    <= '0;
                slip     <= 1'b1;
                settle_q <= '0;
                state_q  <= TR_SETTLE;
                if (slips_q == MW'(MAX_SLIPS - 1)) begin
                  slips_q <= '0;
                  fail    <= 1'b1;
                end else begin
                  slips_q <= slips_q + 1'b1;
                end
              end
            end
          end
          TR_SETTLE: begin
            if (settle_q == SW'(SETTLE_WORDS - 1)) begin
              settle_q <= '0;
              state_q  <= TR_HUNT;
            end else begin
              settle_q <= settle_q + 1'b1;
            end
          end
          TR_LOCKED: begin
            if (!train_en || hit) begin
              miss_q <= '0;
            end else if (miss_q == UW'(UNLOCK_WORDS - 1)) begin
              miss_q  <= '0;
              run_q   <= '0;
              locked  <= 1'b0;
              state_q <= TR_HUNT;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end
          default: state_q <= TR_HUNT;
        endcase
      end
    end
  end

  // checker state: words since the last slip, consecutive idle words seen
  logic [GW-1:0] chk_gap_q;
  logic          chk_slipped_q;
  logic [LW-1:0] chk_run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_gap_q     <= '0;
      chk_slipped_q <= 1'b0;
      chk_run_q     <= '0;
    end else begin
      if (slip) begin
        chk_gap_q     <= '0;
        chk_slipped_q <= 1'b1;
      end else if (word_vld && chk_gap_q != GW'(SETTLE_WORDS + 1)) begin
        chk_gap_q <= chk_gap_q + 1'b1;
      end
      if (word_vld) begin
        if (!hit) chk_run_q <= '0;
        else if (chk_run_q != LW'(LOCK_WORDS)) chk_run_q <= chk_run_q + 1'b1;
      end
    end
  end

  // R5
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (slip && chk_slipped_q) |-> (chk_gap_q >= GW'(SETTLE_WORDS + 1)));

  // R3
  lock_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (chk_run_q >= LW'(LOCK_WORDS)));

  // R7
  drop_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(train_en));

  // R6
  no_slip_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !train_en |=> !slip);

  // R8
  fail_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> !fail);
endmodule

// File: rtl/idle_lane_aligner.sv
`timescale 1ns/1ps
module idle_lane_aligner
  import lanealign_pkg::*;
#(
  parameter int                LANES        = 2,
  parameter int                WORD_W       = 10,
  parameter logic [WORD_W-1:0] IDLE_WORD    = 10'h2E6,
  parameter int                SETTLE_WORDS = 4,
  parameter int                LOCK_WORDS   = 8,
  parameter int                UNLOCK_WORDS = 4,
  parameter int                MAX_SLIPS    = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    train_en,
  input  logic [LANES-1:0]        ser_first,
  input  logic [LANES-1:0]        ser_second,
  output logic [LANES*WORD_W-1:0] rx_word,
  output logic [LANES-1:0]        rx_valid,
  output logic [LANES-1:0]        lane_locked,
  output logic [LANES-1:0]        lane_fail
);

  initial begin
    // R4
    idle_aperiodic_chk: assert (!rot_symmetric(64'(IDLE_WORD), WORD_W))
      else $error("idle word repeats under rotation; alignment would never settle");
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              slip;
    logic [WORD_W-1:0] word;
    logic              vld;

    lane_gearbox #(
      .WORD_W(WORD_W)
    ) u_gear (
      .clk      (clk),
      .rst      (rst),
      .bit_early(ser_first[g]),
      .bit_late (ser_second[g]),
      .slip     (slip),
      .word     (word),
      .word_vld (vld)
    );

    lane_trainer #(
      .WORD_W      (WORD_W),
      .IDLE_WORD   (IDLE_WORD),
      .SETTLE_WORDS(SETTLE_WORDS),
      .LOCK_WORDS  (LOCK_WORDS),
      .UNLOCK_WORDS(UNLOCK_WORDS),
      .MAX_SLIPS   (MAX_SLIPS)
    ) u_train (
      .clk     (clk),
      .rst     (rst),
      .train_en(train_en),
      .word_vld(vld),
      .word    (word),
      .slip    (slip),
      .locked  (lane_locked[g]),
      .fail    (lane_fail[g])
    );

    assign rx_word[g*WORD_W +: WORD_W] = word;
    assign rx_valid[g]                 = vld;
  end
endmodule

// File: tb/idle_lane_aligner_test.sv
`timescale 1ns/1ps
module idle_lane_aligner_test;
  localparam int              W    = 10;
  localparam int              CYC  = W / 2;
  localparam logic [W-1:0]    IDLE = 10'h2E6;
  localparam int              NPAY = 24;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           train_en = 1'b0;
  logic [1:0]     ser_first = '0;
  logic [1:0]     ser_second = '0;
  logic [2*W-1:0] rx_word;
  logic [1:0]     rx_valid;
  logic [1:0]     lane_locked;
  logic [1:0]     lane_fail;

  always #2.5 clk = ~clk;

  idle_lane_aligner uut (
    .clk        (clk),
    .rst        (rst),
    .train_en   (train_en),
    .ser_first  (ser_first),
    .ser_second (ser_second),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid),
    .lane_locked(lane_locked),
    .lane_fail  (lane_fail)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  bit rst_next = 1'b1;

  bit q0[$];
  bit q1[$];
  int mode [2];          // 0 idle, 1 payload list, 2 all zeros
  logic [W-1:0] pay [NPAY];
  int pidx;
  int pptr;
  bit pcheck;
  bit chk_idle [2];
  int strobes [2];
  int lock_at [2];
  int gap [2];
  bit seen_vld [2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_bit(input int l, input bit b);
    if (l == 0) q0.push_back(b); else q1.push_back(b);
  endtask

  task automatic push_word(input int l, input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) push_bit(l, w[i]);
  endtask

  task automatic feed(input int l);
    while (((l == 0) ? q0.size() : q1.size()) < 2 * W) begin
      if (mode[l] == 1) begin
        push_word(l, pay[pidx]);
        pidx++;
        if (pidx == NPAY) mode[l] = 0;
      end else if (mode[l] == 2) begin
        push_word(l, '0);
      end else begin
        push_word(l, IDLE);
      end
    end
  endtask

  task automatic pop_bit(input int l, output bit b);
    if (l == 0) b = q0.pop_front(); else b = q1.pop_front();
  endtask

  task automatic monitor();
    for (int l = 0; l < 2; l++) begin
      logic [W-1:0] w;
      w = rx_word[l*W +: W];
      gap[l]++;
      if (rx_valid[l]) begin
        strobes[l]++;
        // R11: strobe every CYC cycles
        if (seen_vld[l]) chk(gap[l] == CYC, $sformatf("R11 lane%0d strobe spacing", l), gap[l], CYC);
        gap[l] = 0;
        seen_vld[l] = 1'b1;
        // R3 / R1: locked lane on idle shows the idle word, MSB first
        if (lane_locked[l] && chk_idle[l])
          chk(w == IDLE, $sformatf("R3 R1 lane%0d idle word", l), int'(w), int'(IDLE));
        // R2: payload pass-through on lane 0
        if (l == 0 && pcheck) begin
          if (pptr == 0) begin
            if (w == pay[0]) pptr = 1;
          end else if (pptr < NPAY) begin
            chk(w == pay[pptr], $sformatf("R2 payload word %0d", pptr), int'(w), int'(pay[pptr]));
            pptr++;
          end
        end
      end
      if (lane_locked[l] && lock_at[l] < 0) lock_at[l] = strobes[l];
    end
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
    rst = rst_next;
    if (rst) begin
      ser_first  = '0;
      ser_second = '0;
    end else begin
      for (int l = 0; l < 2; l++) begin
        bit a;
        bit b;
        feed(l);
        pop_bit(l, a);
        pop_bit(l, b);
        ser_first[l]  = a;
        ser_second[l] = b;
      end
    end
  endtask

  // reset, then queue k skew bits per lane that cannot complete an idle word
  task automatic restart(input int k0, input int k1, input bit en);
    int k [2];
    k[0] = k0;
    k[1] = k1;
    rst_next = 1'b1;
    repeat (4) step();
    // R10
    chk(lane_locked == 2'b00, "R10 locked cleared", int'(lane_locked), 0);
    chk(lane_fail == 2'b00, "R10 fail cleared", int'(lane_fail), 0);
    chk(rx_valid == 2'b00, "R10 valid cleared", int'(rx_valid), 0);
    q0.delete();
    q1.delete();
    for (int l = 0; l < 2; l++) begin
      mode[l] = 0;
      chk_idle[l] = 1'b1;
      strobes[l] = 0;
      lock_at[l] = -1;
      gap[l] = 0;
      seen_vld[l] = 1'b0;
      for (int j = 0; j < k[l]; j++) push_bit(l, ~IDLE[W-1-j]);
    end
    train_en = en;
    rst_next = 1'b0;
  endtask

  task automatic train_round(input int k0, input int k1);
    int k [2];
    k[0] = k0;
    k[1] = k1;
    restart(k0, k1, 1'b1);
    for (int i = 0; i < 700 && (lock_at[0] < 0 || lock_at[1] < 0); i++) step();
    repeat (40) step();
    for (int l = 0; l < 2; l++) begin
      int s;
      s = (W - k[l]) % W;
      // R4 R5 R9: exact lock strobe per lane from its own skew
      chk(lock_at[l] == 5 * s + 8, $sformatf("R4 R5 R9 lane%0d skew %0d lock strobe", l, k[l]),
          lock_at[l], 5 * s + 8);
      chk(lane_fail[l] == 1'b0, $sformatf("R4 R8 lane%0d no fail", l), int'(lane_fail[l]), 0);
    end
    // R7: matching words keep lock
    chk(lane_locked == 2'b11, "R7 lock held on idle", int'(lane_locked), 3);
  endtask

  initial begin
    void'($urandom(32'd4711));
    pidx = 0;
    pptr = 0;
    pcheck = 1'b0;

    // directed skews, then random ones
    train_round(0, 9);
    train_round(1, 5);
    train_round(9, 0);
    for (int r = 0; r < 4; r++) train_round(int'($urandom % W), int'($urandom % W));

    // R6: training disabled, aligned idle, no lock
    restart(0, 0, 1'b0);
    repeat (200) step();
    chk(lane_locked == 2'b00, "R6 no lock while disabled", int'(lane_locked), 0);
    train_en = 1'b1;
    for (int i = 0; i < 200 && lane_locked != 2'b11; i++) step();
    chk(lane_locked == 2'b11, "R6 lock after enable", int'(lane_locked), 3);

    // R2 / R6: payload passes through on lane 0 with training off
    train_round(3, 7);
    train_en = 1'b0;
    for (int i = 0; i < NPAY; i++) pay[i] = W'($urandom);
    if (pay[0] == IDLE) pay[0] = ~IDLE;
    pidx = 0;
    pptr = 0;
    pcheck = 1'b1;
    chk_idle[0] = 1'b0;
    mode[0] = 1;
    repeat (NPAY * CYC + 100) step();
    pcheck = 1'b0;
    chk(pptr == NPAY, "R2 payload sequence complete", pptr, NPAY);
    chk(lane_locked == 2'b11, "R6 lock held through payload", int'(lane_locked), 3);

    // R7 / R9: lane 1 sees non-idle with training on
    train_en = 1'b1;
    chk_idle[1] = 1'b0;
    mode[1] = 2;
    for (int i = 0; i < 200 && lane_locked[1]; i++) step();
    chk(lane_locked[1] == 1'b0, "R7 lane1 drops lock", int'(lane_locked[1]), 0);
    chk(lane_locked[0] == 1'b1, "R9 lane0 keeps lock", int'(lane_locked[0]), 1);

    // R8: slip budget exhausted
    for (int i = 0; i < 600 && !lane_fail[1]; i++) step();
    chk(lane_fail[1] == 1'b1, "R8 lane1 fail raised", int'(lane_fail[1]), 1);
    chk(lane_fail[0] == 1'b0, "R9 lane0 fail clear", int'(lane_fail[0]), 0);
    chk(lane_locked[0] == 1'b1, "R9 lane0 still locked", int'(lane_locked[0]), 1);

    // R8: search continues and lock clears the flag
    mode[1] = 0;
    chk_idle[1] = 1'b1;
    for (int i = 0; i < 600 && !lane_locked[1]; i++) step();
    chk(lane_locked[1] == 1'b1, "R8 lane1 relocks", int'(lane_locked[1]), 1);
    chk(lane_fail[1] == 1'b0, "R8 fail cleared on lock", int'(lane_fail[1]), 0);
    repeat (20) step();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule